// File: doc/BRIEF.md
# Character Overlay Raster Generator

This block turns a character display memory and an external dot-matrix font into a per-pixel text overlay. It runs on the dot clock and follows the video timing from single-cycle horizontal and vertical sync pulses. The text area is a fixed grid of 24 columns by 12 rows of cells. Each cell is 12 dots wide and 18 scan lines tall. The area can be moved on both axes and magnified on each axis independently.

On every scan line inside the area, the block reads each cell's word from the display memory and the font row for that cell and line. It holds the row in a shift register and sends the dots out in order. The read for the next cell is made while the current cell is still being shown, so there is no gap between cells. Blinking, whole-cell blanking and up to three text-row background bands are applied as the pixels leave the block. Analog mixing, sync separation, host access and the font contents stay outside the block.

Top module: `txt_overlay`

## Requirements
- R1: While `rst_n` is low, and after it is released until a text line is reached, `px_char`, `px_blank` and `px_band` are low.
- R2: The grid is 24 columns by 12 rows. The cell at text row r and column c is read at `cell_addr` = r*24 + c. The area is 24*12*hf dots wide and 12*18*vf lines tall.
- R3: The first dot of the area appears H_LEAD + 4*`h_start` clocks after the clock edge that samples `hsync`. The first text line is the line that begins with hsync pulse number V_LEAD + 2*`v_start` after `vsync`. Defaults: H_LEAD=8, V_LEAD=4.
- R4: A magnification select of 00, 01, 10 or 11 gives a factor of 1, 2, 3 or 3. Each font dot lasts hf clocks and each font row lasts vf lines.
- R5: `font_code` carries bits 6:0 of the cell word, and `font_row` carries the row (0..17) inside the cell. Bit 11 of `font_bits` is the leftmost dot.
- R6: Cell word bits 7:0 are the code. Codes 0x00-0x7F draw a glyph. 0x81 is a transparent space that gives no character, no blanking and no band. Any other code of 0x80 or above is a blank space: no character, but blanking and band still apply.
- R7: Cell word bit 8 turns on blinking for that cell. The blink phase starts in the on state after reset. It toggles every 30 `vsync` pulses when `blink_slow`=1 and every 15 when it is 0. In the off state a blinking cell gives neither character nor blanking.
- R8: With `blank_en` high, `px_blank` is high on every dot of every visible, non-transparent cell in the area.
- R9: Band k (k=0..2) covers text row `band_rows[4k+3:4k]` when `band_en[k]` is set. `px_band` is high across the area width on the lines of any covered row, except on transparent cells.
- R10: All three outputs are low outside the text area. This holds to the left and right of it, above it, below it, and after each `hsync`.
- R11: Pixels continue without a gap across cell boundaries. The last dot of a cell is followed directly by the first dot of the next cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low reset |
| hsync | input | 1 | One-cycle pulse at the start of each line |
| vsync | input | 1 | One-cycle pulse at the start of each field |
| h_start | input | 6 | Horizontal start step |
| v_start | input | 6 | Vertical start step |
| h_mag | input | 2 | Horizontal magnification select |
| v_mag | input | 2 | Vertical magnification select |
| blink_slow | input | 1 | 1: slow blink period, 0: fast |
| blank_en | input | 1 | Enable whole-cell blanking |
| band_rows | input | 12 | Three 4-bit text-row selectors for the bands |
| band_en | input | 3 | Enable per band |
| cell_addr | output | 9 | Display memory read address |
| cell_word | input | 9 | Display memory word (bit 8 blink, 7:0 code) |
| font_code | output | 7 | Font read glyph index |
| font_row | output | 5 | Font read row inside the cell |
| font_bits | input | 12 | Font row, bit 11 leftmost |
| px_char | output | 1 | Glyph dot |
| px_blank | output | 1 | Cell blanking |
| px_band | output | 1 | Line background band |

## Verification
The assertions assume that both memory read ports answer in the same cycle they are addressed. They also assume that `hsync` and `vsync` never occur in the same cycle, and that the position, magnification and mode inputs stay constant during a field. The bench drives the two sync pulses on separate clocks and only issues `vsync` after a line has run past the right edge of the area. It changes settings only between fields, and it models both memories as combinational lookups.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
   localparam int GRID_COLS  = 24;
   localparam int GRID_ROWS  = 12;
   localparam int GLYPH_W    = 12;
   localparam int GLYPH_H    = 18;
   localparam int POS_W      = 6;
   localparam int WORD_W     = 9;
   localparam logic [7:0] CODE_CLEAR = 8'h81;

   function automatic logic [1:0] mag_factor(input logic [1:0] sel);
      case (sel)
         2'b00:   return 2'd1;
         2'b01:   return 2'd2;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/ovl_vscan.sv
module ovl_vscan #(
   parameter int ROWS   = 12,
   parameter int CELL_H = 18,
   parameter int VCNT_W = 10,
   parameter int ROW_W  = 4,
   parameter int FROW_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync,
   input  logic              vsync,
   input  logic [VCNT_W-1:0] vy0,
   input  logic [1:0]        vfac,
   output logic              v_act,
   output logic [ROW_W-1:0]  trow,
   output logic [FROW_W-1:0] frow
);
   if (ROWS < 1 || CELL_H < 2 || (1 << ROW_W) < ROWS || (1 << FROW_W) < CELL_H) begin : g_bad_geom
      $error("ovl_vscan: geometry does not fit counter widths");
   end

   logic [VCNT_W-1:0] vcnt;
   logic [VCNT_W-1:0] vnext;
   logic [1:0]        vrep;

   assign vnext = (vcnt == '1) ? vcnt : vcnt + VCNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vcnt  <= '0;
         v_act <= 1'b0;
         trow  <= '0;
         frow  <= '0;
         vrep  <= '0;
      end else if (vsync) begin
         vcnt  <= '0;
         v_act <= 1'b0;
         trow  <= '0;
         frow  <= '0;
         vrep  <= '0;
      end else if (hsync) begin
         vcnt <= vnext;
         if (vnext == vy0) begin
            v_act <= 1'b1;
            trow  <= '0;
            frow  <= '0;
            vrep  <= '0;
         end else if (v_act) begin
            if (vrep == vfac - 2'd1) begin
               vrep <= '0;
               if (frow == FROW_W'(CELL_H - 1)) begin
                  frow <= '0;
                  if (trow == ROW_W'(ROWS - 1)) v_act <= 1'b0;
                  else                          trow  <= trow + ROW_W'(1);
               end else begin
                  frow <= frow + FROW_W'(1);
               end
            end else begin
               vrep <= vrep + 2'd1;
            end
         end
      end
   end

   // R10: a field start ends any text area
   p_vsync_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> !v_act);
   // R2: row trackers stay inside the grid
   p_row_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (trow < ROW_W'(ROWS)) && (frow < FROW_W'(CELL_H)));
   // R4: scan position moves only on line boundaries
   p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hsync && !vsync) |=> ($stable(trow) && $stable(frow)));
endmodule

// File: rtl/ovl_hscan.sv
module ovl_hscan #(
   parameter int COLS   = 24,
   parameter int CELL_W = 12,
   parameter int HCNT_W = 12,
   parameter int WORD_W = 9,
   parameter int COL_W  = 5,
   parameter int DOT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync,
   input  logic              v_act,
   input  logic [HCNT_W-1:0] hx0,
   input  logic [1:0]        hfac,
   input  logic [CELL_W-1:0] font_bits,
   input  logic [WORD_W-1:0] cell_word,
   output logic [COL_W-1:0]  col,
   output logic              act,
   output logic              dot_bit,
   output logic [WORD_W-1:0] word_q
);
   if (COLS < 1 || CELL_W < 2 || (1 << COL_W) <= COLS || (1 << DOT_W) < CELL_W) begin : g_bad_geom
      $error("ovl_hscan: geometry does not fit counter widths");
   end

   logic [HCNT_W-1:0] hcnt;
   logic [CELL_W-1:0] shift_q;
   logic [DOT_W-1:0]  dot;
   logic [1:0]        rep;
   logic              last_dot;
   logic              first_load;
   logic              next_load;

   assign last_dot   = (dot == DOT_W'(CELL_W - 1)) && (rep == hfac - 2'd1);
   assign first_load = v_act && !act && (hcnt == hx0 - HCNT_W'(1));
   assign next_load  = act && last_dot && (col != COL_W'(COLS));
   assign dot_bit    = shift_q[CELL_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hcnt <= '0;
      else if (hsync)           hcnt <= '0;
      else if (hcnt != '1)      hcnt <= hcnt + HCNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= 1'b0;
         col     <= '0;
         dot     <= '0;
         rep     <= '0;
         shift_q <= '0;
         word_q  <= '0;
      end else if (hsync) begin
         act <= 1'b0;
         col <= '0;
         dot <= '0;
         rep <= '0;
      end else if (first_load || next_load) begin
         shift_q <= font_bits;
         word_q  <= cell_word;
         col     <= col + COL_W'(1);
         act     <= 1'b1;
         dot     <= '0;
         rep     <= '0;
      end else if (act) begin
         if (last_dot) begin
            act <= 1'b0;
         end else if (rep == hfac - 2'd1) begin
            rep     <= '0;
            dot     <= dot + DOT_W'(1);
            shift_q <= {shift_q[CELL_W-2:0], 1'b0};
         end else begin
            rep <= rep + 2'd1;
         end
      end
   end

   // R3: the area opens exactly one clock after the pre-start count
   p_start_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> ($past(hcnt) == hx0 - HCNT_W'(1)));
   // R2: fetch column never runs past the grid
   p_col_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      col <= COL_W'(COLS));
   // R4: dot repeat stays below the horizontal factor
   p_rep_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (rep < hfac));
   // R10: a line start closes the area
   p_hsync_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |=> !act);
endmodule

// File: rtl/ovl_blink.sv
module ovl_blink #(
   parameter int SLOW = 30,
   parameter int FAST = 15,
   parameter int CW   = $clog2(SLOW + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync,
   input  logic slow,
   output logic phase
);
   if (FAST < 1 || SLOW < FAST) begin : g_bad_period
      $error("ovl_blink: periods must satisfy 1 <= FAST <= SLOW");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim = slow ? CW'(SLOW) : CW'(FAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (vsync) begin
         if (cnt >= lim - CW'(1)) begin
            cnt   <= '0;
            phase <= ~phase;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   // R7: phase changes only on a field pulse
   p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> $stable(phase));
   // R7: field counter stays inside the longest period
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(SLOW));
endmodule

// File: rtl/txt_overlay.sv
module txt_overlay
   import ovl_pkg::*;
#(
   parameter int COLS       = GRID_COLS,
   parameter int ROWS       = GRID_ROWS,
   parameter int CELL_W     = GLYPH_W,
   parameter int CELL_H     = GLYPH_H,
   parameter int H_STEP     = 4,
   parameter int V_STEP     = 2,
   parameter int H_LEAD     = 8,
   parameter int V_LEAD     = 4,
   parameter int HCNT_W     = 12,
   parameter int VCNT_W     = 10,
   parameter int NBANDS     = 3,
   parameter int BLINK_SLOW = 30,
   parameter int BLINK_FAST = 15
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hsync,
   input  logic        vsync,
   input  logic [5:0]  h_start,
   input  logic [5:0]  v_start,
   input  logic [1:0]  h_mag,
   input  logic [1:0]  v_mag,
   input  logic        blink_slow,
   input  logic        blank_en,
   input  logic [11:0] band_rows,
   input  logic [2:0]  band_en,
   output logic [8:0]  cell_addr,
   input  logic [8:0]  cell_word,
   output logic [6:0]  font_code,
   output logic [4:0]  font_row,
   input  logic [11:0] font_bits,
   output logic        px_char,
   output logic        px_blank,
   output logic        px_band
);
   localparam int ADDR_W = $clog2(COLS * ROWS);
   localparam int ROW_W  = $clog2(ROWS);
   localparam int FROW_W = $clog2(CELL_H);
   localparam int COL_W  = $clog2(COLS + 1);
   localparam int DOT_W  = $clog2(CELL_W);
   localparam int H_SPAN = H_LEAD + ((1 << POS_W) - 1) * H_STEP + COLS * CELL_W * 3;
   localparam int V_SPAN = V_LEAD + ((1 << POS_W) - 1) * V_STEP + ROWS * CELL_H * 3;

   if (H_LEAD < 1 || V_LEAD < 1) begin : g_bad_lead
      $error("txt_overlay: lead offsets must be at least 1");
   end
   if (H_SPAN >= (1 << HCNT_W) || V_SPAN >= (1 << VCNT_W)) begin : g_bad_span
      $error("txt_overlay: position counters too narrow");
   end
   if (ADDR_W != 9 || ROW_W != 4 || FROW_W != 5 || CELL_W != 12 || NBANDS != 3) begin : g_bad_ports
      $error("txt_overlay: port widths assume the default grid");
   end

   logic [HCNT_W-1:0] hx0;
   logic [VCNT_W-1:0] vy0;
   logic [1:0]        hfac, vfac;
   logic              v_act, h_act, act;
   logic [ROW_W-1:0]  trow;
   logic [FROW_W-1:0] frow;
   logic [COL_W-1:0]  col;
   logic              dot_bit;
   logic [WORD_W-1:0] word_q;
   logic              phase;
   logic [NBANDS-1:0] band_hit;
   logic              is_glyph, is_clear, hidden;

   assign hx0  = HCNT_W'(H_LEAD) + HCNT_W'(h_start) * HCNT_W'(H_STEP);
   assign vy0  = VCNT_W'(V_LEAD) + VCNT_W'(v_start) * VCNT_W'(V_STEP);
   assign hfac = mag_factor(h_mag);
   assign vfac = mag_factor(v_mag);

   ovl_vscan #(.ROWS(ROWS), .CELL_H(CELL_H), .VCNT_W(VCNT_W), .ROW_W(ROW_W), .FROW_W(FROW_W)) u_vscan (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .vy0(vy0), .vfac(vfac),
      .v_act(v_act), .trow(trow), .frow(frow)
   );

   ovl_hscan #(.COLS(COLS), .CELL_W(CELL_W), .HCNT_W(HCNT_W), .WORD_W(WORD_W),
               .COL_W(COL_W), .DOT_W(DOT_W)) u_hscan (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .v_act(v_act), .hx0(hx0), .hfac(hfac),
      .font_bits(font_bits), .cell_word(cell_word),
      .col(col), .act(h_act), .dot_bit(dot_bit), .word_q(word_q)
   );

   ovl_blink #(.SLOW(BLINK_SLOW), .FAST(BLINK_FAST)) u_blink (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .slow(blink_slow), .phase(phase)
   );

   assign cell_addr = ADDR_W'(trow) * ADDR_W'(COLS) + ADDR_W'(col);
   assign font_code = cell_word[6:0];
   assign font_row  = frow;

   for (genvar k = 0; k < NBANDS; k++) begin : g_band
      assign band_hit[k] = band_en[k] && (band_rows[4*k +: 4] == 4'(trow));
   end

   assign act      = h_act && v_act;
   assign is_glyph = !word_q[7];
   assign is_clear = (word_q[7:0] == CODE_CLEAR);
   assign hidden   = word_q[8] && phase;

   assign px_char  = act && is_glyph && dot_bit && !hidden;
   assign px_blank = act && blank_en && !is_clear && !hidden;
   assign px_band  = act && (|band_hit) && !is_clear;

   // R6: a transparent cell leaves every output low
   p_clear_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (h_act && word_q[7:0] == 8'h81) |-> !(px_char || px_blank || px_band));
   // R7: a blinking cell in its off phase shows nothing of its own
   p_blink_hide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (h_act && word_q[8] && phase) |-> !(px_char || px_blank));
   // R10: no overlay outside the scanned area
   p_quiet_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !h_act |-> !(px_char || px_blank || px_band));
endmodule

// File: tb/sim_txt_overlay.sv
module sim_txt_overlay;
   logic        clk = 1'b0;
   logic        rst_n, hsync, vsync;
   logic [5:0]  h_start, v_start;
   logic [1:0]  h_mag, v_mag;
   logic        blink_slow, blank_en;
   logic [11:0] band_rows;
   logic [2:0]  band_en;
   logic [8:0]  cell_addr, cell_word;
   logic [6:0]  font_code;
   logic [4:0]  font_row;
   logic [11:0] font_bits;
   logic        px_char, px_blank, px_band;

   logic [8:0]  mem [0:287];
   int n_run = 0, n_fail = 0, line_no = 0, fields = 0;

   always #5 clk = ~clk;

   txt_overlay u0 (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .h_start(h_start), .v_start(v_start), .h_mag(h_mag), .v_mag(v_mag),
      .blink_slow(blink_slow), .blank_en(blank_en), .band_rows(band_rows), .band_en(band_en),
      .cell_addr(cell_addr), .cell_word(cell_word), .font_code(font_code), .font_row(font_row),
      .font_bits(font_bits), .px_char(px_char), .px_blank(px_blank), .px_band(px_band)
   );

   function automatic logic [11:0] fnt(input logic [6:0] c, input logic [4:0] r);
      logic [11:0] a;
      a = 12'(c) * 12'd29 + 12'(r) * 12'd7 + 12'h5A5;
      return a ^ {c[4:0], 7'h00};
   endfunction

   assign cell_word = (cell_addr < 9'd288) ? mem[cell_addr] : 9'h000;
   assign font_bits = fnt(font_code, font_row);

   function automatic int magf(input logic [1:0] m);
      return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 3;
   endfunction

   // Reference: expected {char, blank, band} at line L, dot n after hsync
   function automatic logic [2:0] expect_px(input int L, input int n);
      int hf, vf, x, y, tr, fr, cl, dt, per, ph;
      logic [8:0] w;
      logic clear, hide, ch, bl, bd;
      hf = magf(h_mag); vf = magf(v_mag);
      x = n - (8 + 4 * int'(h_start));
      y = L - (4 + 2 * int'(v_start));
      if (x < 0 || y < 0 || x >= 24 * 12 * hf || y >= 12 * 18 * vf) return 3'b000;
      tr = y / (18 * vf); fr = (y % (18 * vf)) / vf;
      cl = x / (12 * hf); dt = (x % (12 * hf)) / hf;
      w = mem[tr * 24 + cl];
      per = blink_slow ? 30 : 15;
      ph = (fields / per) % 2;
      clear = (w[7:0] == 8'h81);
      hide = w[8] && (ph == 1);
      ch = !w[7] && fnt(w[6:0], 5'(fr))[11 - dt] && !hide;
      bl = blank_en && !clear && !hide;
      bd = !clear && ((band_en[0] && band_rows[3:0] == 4'(tr)) ||
                      (band_en[1] && band_rows[7:4] == 4'(tr)) ||
                      (band_en[2] && band_rows[11:8] == 4'(tr)));
      return {ch, bl, bd};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      line_no = 0; fields = 0;
   endtask

   task automatic do_vsync();
      @(negedge clk) vsync = 1'b1;
      @(negedge clk) vsync = 1'b0;
      line_no = 0; fields++;
   endtask

   // One line: pulse hsync, then compare len dots against the reference
   task automatic run_line(input int len, input string tag);
      int bad, fn;
      logic [2:0] a, e, fa, fe;
      bad = 0; fn = 0; fa = 3'b000; fe = 3'b000;
      @(negedge clk) hsync = 1'b1;
      @(negedge clk) hsync = 1'b0;
      line_no++;
      for (int n = 0; n < len; n++) begin
         e = expect_px(line_no, n);
         a = {px_char, px_blank, px_band};
         if (a !== e) begin
            if (bad == 0) begin fn = n; fa = a; fe = e; end
            bad++;
         end
         @(negedge clk);
      end
      n_run++;
      if (bad != 0) begin
         n_fail++;
         $display("FAIL %s line %0d dot %0d: got %b expected %b", tag, line_no, fn, fa, fe);
      end
   endtask

   function automatic int full_len();
      return 8 + 4 * int'(h_start) + 24 * 12 * magf(h_mag) + 4;
   endfunction

   task automatic t_reset();
      rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0;
      repeat (2) @(negedge clk);
      n_run++;
      if ({px_char, px_blank, px_band} !== 3'b000) begin
         n_fail++;
         $display("FAIL R1 in reset: got %b expected 000", {px_char, px_blank, px_band});
      end
      rst_n = 1'b1;
      line_no = 0; fields = 0;
      repeat (20) @(negedge clk);
      n_run++;
      if ({px_char, px_blank, px_band} !== 3'b000) begin
         n_fail++;
         $display("FAIL R1 after reset: got %b expected 000", {px_char, px_blank, px_band});
      end
   endtask

   // R2 R3 R5 R6 R8 R9 R10 R11 at unit size
   task automatic t_basic();
      h_start = 6'd1; v_start = 6'd1; h_mag = 2'b00; v_mag = 2'b00;
      blank_en = 1'b1; band_rows = {4'd2, 4'd5, 4'd0}; band_en = 3'b101;
      do_vsync();
      for (int i = 0; i < 62; i++) run_line(full_len(), "R2/R3/R6/R8/R9/R11 basic");
   endtask

   // R4: 2x horizontal, 3x vertical
   task automatic t_mag();
      h_start = 6'd0; v_start = 6'd3; h_mag = 2'b01; v_mag = 2'b10;
      blank_en = 1'b0; band_rows = {4'd0, 4'd1, 4'd3}; band_en = 3'b010;
      do_vsync();
      for (int i = 0; i < 70; i++) run_line(full_len(), "R4 mag 2x3");
   endtask

   // R3 R4: select 11 acts as 3x, far right start
   task automatic t_mag3h();
      h_start = 6'd63; v_start = 6'd0; h_mag = 2'b11; v_mag = 2'b00;
      blank_en = 1'b1; band_en = 3'b001; band_rows = 12'h000;
      do_vsync();
      for (int i = 0; i < 12; i++) run_line(full_len(), "R3/R4 mag3 right edge");
   endtask

   // R2 R10: bottom row and the line after it, lowest start
   task automatic t_bottom();
      h_start = 6'd0; v_start = 6'd63; h_mag = 2'b00; v_mag = 2'b00;
      blank_en = 1'b1; band_rows = {4'd11, 4'd11, 4'd11}; band_en = 3'b100;
      do_vsync();
      for (int i = 0; i < 349; i++)
         run_line((i >= 328) ? full_len() : 16, "R2/R10 bottom");
   endtask

   // R7: slow period, on then off phase
   task automatic t_blink_slow();
      do_reset();
      blink_slow = 1'b1; blank_en = 1'b1; h_start = 6'd0; v_start = 6'd0;
      h_mag = 2'b00; v_mag = 2'b00; band_en = 3'b000;
      do_vsync();
      for (int i = 0; i < 24; i++) run_line(full_len(), "R7 slow on");
      repeat (29) do_vsync();
      for (int i = 0; i < 24; i++) run_line(full_len(), "R7 slow off");
   endtask

   // R7: fast period
   task automatic t_blink_fast();
      do_reset();
      blink_slow = 1'b0;
      repeat (15) do_vsync();
      for (int i = 0; i < 24; i++) run_line(full_len(), "R7 fast off");
      repeat (15) do_vsync();
      for (int i = 0; i < 24; i++) run_line(full_len(), "R7 fast on");
   endtask

   initial begin
      for (int i = 0; i < 288; i++) begin
         logic [7:0] c;
         if (i % 11 == 4)      c = 8'h81;
         else if (i % 13 == 6) c = 8'h80;
         else if (i % 5 == 2)  c = 8'hC3;
         else                  c = 8'((i * 37 + 5) % 128);
         mem[i] = {(i % 7 == 3) ? 1'b1 : 1'b0, c};
      end
      h_start = 6'd0; v_start = 6'd0; h_mag = 2'b00; v_mag = 2'b00;
      blink_slow = 1'b1; blank_en = 1'b0; band_rows = 12'h000; band_en = 3'b000;
      t_reset();
      t_basic();
      t_mag();
      t_mag3h();
      t_bottom();
      t_blink_slow();
      t_blink_fast();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1900000;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule